// File: doc/BRIEF.md
# NCO Fine Complex Frequency Shifter

This block moves a stream of complex baseband samples up or down in frequency. A numerically controlled oscillator drives it: a 24-bit phase accumulator whose upper bits address a sine/cosine table. The table is built from a quarter wave at elaboration. Each accepted sample is multiplied by the oscillator phasor. The result is rounded and saturated back to the sample width.

The shift in hertz is `ftw * Fs / 2^24`. `ftw` is read as an unsigned binary number, and Fs is the rate of valid samples. A select input picks the direction of the shift at run time. When the fine-mode enable is low, both the oscillator and the mixer are bypassed, and each sample leaves unchanged after the same three-cycle delay. The mixer always works as a complex multiplier.

Top module: `nco_fine_shifter`

## Requirements
- R1: A synchronous active-high `rst` clears `out_valid`, `out_i`, `out_q` and the phase accumulator to zero by the next clock edge.
- R2: `out_valid` equals `in_valid` delayed by exactly three clock cycles, in both modes.
- R3: With `fine_en` low for a sample, its `out_i`/`out_q` equal its `in_i`/`in_q` exactly.
- R4: The accumulator starts at zero. A sample uses the value held before its own update. It advances by `ftw` (mod 2^24) only on a cycle with `in_valid` and `fine_en` both high, and it holds otherwise.
- R5: The table index p is the top 8 accumulator bits. With m = p mod 128, sin(p) = 32767·m·(128−m)/4096 truncated, negated when p ≥ 128. cos(p) = sin((p+64) mod 256).
- R6: With `neg_shift` low: I' = I·cos − Q·sin and Q' = I·sin + Q·cos.
- R7: With `neg_shift` high the conjugate phasor is used: I' = I·cos + Q·sin and Q' = Q·cos − I·sin.
- R8: Each sum is rounded by adding 2^14 and then arithmetic-shifting right by 15.
- R9: Rounded results outside [−32768, 32767] clamp to the nearer limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample strobe |
| in_i | input | 16 | In-phase sample, two's complement |
| in_q | input | 16 | Quadrature sample, two's complement |
| ftw | input | 24 | Unsigned frequency tuning word |
| fine_en | input | 1 | 1: shift enabled, 0: bypass |
| neg_shift | input | 1 | 1: shift down, 0: shift up |
| out_valid | output | 1 | Output sample strobe |
| out_i | output | 16 | Shifted in-phase sample |
| out_q | output | 16 | Shifted quadrature sample |

## Verification
A bad accumulator update produces no error on the first sample. It appears on the next shifted sample, three cycles after that sample enters. From then on every later output follows a rotated phasor, so an error of one step grows with each sample. A wrong table entry shows only on the samples whose index reaches it. Sweeping the tuning word across coarse steps and the wrap point covers every quadrant fold. A wrong rounding or clamp shows at once on directed full-scale inputs at a 45-degree phase.

// File: rtl/nco_shift_pkg.sv
package nco_shift_pkg;

  // round half up by dropping frac bits, then clamp to a signed ow-bit range
  function automatic longint round_sat(input longint acc, input int frac, input int ow);
    longint r;
    longint hi;
    longint lo;
    r  = (acc + (64'sd1 <<< (frac - 1))) >>> frac;
    hi = (64'sd1 <<< (ow - 1)) - 64'sd1;
    lo = -(64'sd1 <<< (ow - 1));
    if (r > hi) return hi;
    if (r < lo) return lo;
    return r;
  endfunction

  // parabolic quarter-wave sample k of q steps, amplitude 2^(cw-1)-1
  function automatic longint quarter_amp(input int k, input int q, input int cw);
    longint amp;
    amp = (64'sd1 <<< (cw - 1)) - 64'sd1;
    return (amp * longint'(k) * longint'(2 * q - k)) / longint'(q * q);
  endfunction

endpackage

// File: rtl/nco_phase_lut.sv
module nco_phase_lut
  import nco_shift_pkg::*;
#(
  parameter int PW = 24,
  parameter int AW = 8,
  parameter int CW = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 adv,
  input  logic [PW-1:0]        ftw,
  output logic [PW-1:0]        phase,
  output logic signed [CW-1:0] sin_o,
  output logic signed [CW-1:0] cos_o
);
  localparam int Q = 1 << (AW - 2);

  logic signed [CW-1:0] qtab [0:Q];

  for (genvar k = 0; k <= Q; k++) begin : g_qtab
    assign qtab[k] = CW'(quarter_amp(k, Q, CW));
  end

  function automatic logic signed [CW-1:0] wave(input logic [AW-1:0] ix);
    logic [AW-2:0]        off;
    logic signed [CW-1:0] m;
    off = ix[AW-2] ? (AW-1)'(Q) - {1'b0, ix[AW-3:0]} : {1'b0, ix[AW-3:0]};
    m   = qtab[off];
    return ix[AW-1] ? -m : m;
  endfunction

  logic [AW-1:0] idx;
  assign idx   = phase[PW-1 -: AW];
  assign sin_o = wave(idx);
  assign cos_o = wave(AW'(idx + AW'(Q)));

  always_ff @(posedge clk) begin
    if (rst)      phase <= '0;
    else if (adv) phase <= phase + ftw;
  end
endmodule

// File: rtl/cmix_mult.sv
module cmix_mult #(
  parameter int DW = 16,
  parameter int CW = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic signed [DW-1:0]    a_i,
  input  logic signed [DW-1:0]    a_q,
  input  logic signed [CW-1:0]    w_sin,
  input  logic signed [CW-1:0]    w_cos,
  output logic signed [DW+CW-1:0] p_ic,
  output logic signed [DW+CW-1:0] p_qs,
  output logic signed [DW+CW-1:0] p_is,
  output logic signed [DW+CW-1:0] p_qc
);
  always_ff @(posedge clk) begin
    if (rst) begin
      p_ic <= '0;
      p_qs <= '0;
      p_is <= '0;
      p_qc <= '0;
    end else begin
      p_ic <= a_i * w_cos;
      p_qs <= a_q * w_sin;
      p_is <= a_i * w_sin;
      p_qc <= a_q * w_cos;
    end
  end
endmodule

// File: rtl/cmix_round.sv
module cmix_round
  import nco_shift_pkg::*;
#(
  parameter int DW = 16,
  parameter int CW = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    v_in,
  input  logic                    mix,
  input  logic signed [DW-1:0]    raw_i,
  input  logic signed [DW-1:0]    raw_q,
  input  logic signed [DW+CW-1:0] p_ic,
  input  logic signed [DW+CW-1:0] p_qs,
  input  logic signed [DW+CW-1:0] p_is,
  input  logic signed [DW+CW-1:0] p_qc,
  output logic                    v_out,
  output logic signed [DW-1:0]    y_i,
  output logic signed [DW-1:0]    y_q
);
  localparam int SW = DW + CW + 1;

  logic signed [SW-1:0] sum_i;
  logic signed [SW-1:0] sum_q;
  logic signed [DW-1:0] rs_i;
  logic signed [DW-1:0] rs_q;

  always_comb begin
    sum_i = SW'(p_ic) - SW'(p_qs);
    sum_q = SW'(p_is) + SW'(p_qc);
    rs_i  = DW'(round_sat(longint'(sum_i), CW - 1, DW));
    rs_q  = DW'(round_sat(longint'(sum_q), CW - 1, DW));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v_out <= 1'b0;
      y_i   <= '0;
      y_q   <= '0;
    end else begin
      v_out <= v_in;
      y_i   <= mix ? rs_i : raw_i;
      y_q   <= mix ? rs_q : raw_q;
    end
  end
endmodule

// File: rtl/nco_fine_shifter.sv
module nco_fine_shifter #(
  parameter int DW = 16,
  parameter int PW = 24,
  parameter int AW = 8,
  parameter int CW = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_i,
  input  logic signed [DW-1:0] in_q,
  input  logic [PW-1:0]        ftw,
  input  logic                 fine_en,
  input  logic                 neg_shift,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_i,
  output logic signed [DW-1:0] out_q
);
  localparam int PRW = DW + CW;

  logic                 adv_w;
  logic [PW-1:0]        phase_w;
  logic signed [CW-1:0] sin_w;
  logic signed [CW-1:0] cos_w;

  assign adv_w = in_valid & fine_en;

  nco_phase_lut #(.PW(PW), .AW(AW), .CW(CW)) u_nco (
    .clk(clk), .rst(rst), .adv(adv_w), .ftw(ftw),
    .phase(phase_w), .sin_o(sin_w), .cos_o(cos_w)
  );

  // stage 1: capture sample and oscillator value (conjugated on demand)
  logic                 s1_v, s1_fine;
  logic signed [DW-1:0] s1_i, s1_q;
  logic signed [CW-1:0] s1_sin, s1_cos;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v <= 1'b0; s1_fine <= 1'b0;
      s1_i <= '0;   s1_q    <= '0;
      s1_sin <= '0; s1_cos  <= '0;
    end else begin
      s1_v    <= in_valid;
      s1_fine <= fine_en;
      s1_i    <= in_i;
      s1_q    <= in_q;
      s1_sin  <= neg_shift ? -sin_w : sin_w;
      s1_cos  <= cos_w;
    end
  end

  // stage 2: products, with bypass data carried alongside
  logic                  s2_v, s2_fine;
  logic signed [DW-1:0]  s2_i, s2_q;
  logic signed [PRW-1:0] p_ic, p_qs, p_is, p_qc;

  cmix_mult #(.DW(DW), .CW(CW)) u_mult (
    .clk(clk), .rst(rst), .a_i(s1_i), .a_q(s1_q), .w_sin(s1_sin), .w_cos(s1_cos),
    .p_ic(p_ic), .p_qs(p_qs), .p_is(p_is), .p_qc(p_qc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s2_v <= 1'b0; s2_fine <= 1'b0;
      s2_i <= '0;   s2_q    <= '0;
    end else begin
      s2_v    <= s1_v;
      s2_fine <= s1_fine;
      s2_i    <= s1_i;
      s2_q    <= s1_q;
    end
  end

  // stage 3: sum, round, clamp or pass through
  cmix_round #(.DW(DW), .CW(CW)) u_round (
    .clk(clk), .rst(rst), .v_in(s2_v), .mix(s2_fine),
    .raw_i(s2_i), .raw_q(s2_q),
    .p_ic(p_ic), .p_qs(p_qs), .p_is(p_is), .p_qc(p_qc),
    .v_out(out_valid), .y_i(out_i), .y_q(out_q)
  );
endmodule

// File: rtl/nco_shift_chk.sv
module nco_shift_chk #(
  parameter int DW = 16,
  parameter int PW = 24,
  parameter int CW = 16
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_valid,
  input logic signed [DW-1:0] in_i,
  input logic signed [DW-1:0] in_q,
  input logic [PW-1:0]        ftw,
  input logic                 fine_en,
  input logic                 out_valid,
  input logic signed [DW-1:0] out_i,
  input logic signed [DW-1:0] out_q,
  input logic [PW-1:0]        phase_w,
  input logic signed [CW-1:0] sin_w
);
  localparam logic signed [CW-1:0] MOSTNEG = {1'b1, {(CW-1){1'b0}}};

  logic [1:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst)                 since_rst <= 2'd0;
    else if (since_rst != 3) since_rst <= since_rst + 2'd1;
  end

  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && out_i == '0 && out_q == '0 && phase_w == '0));

  // R2
  valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 3) |-> (out_valid == $past(in_valid, 3)));

  // R3
  bypass_exact_chk: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 3 && $past(in_valid && !fine_en, 3))
      |-> (out_i == $past(in_i, 3) && out_q == $past(in_q, 3)));

  // R4
  phase_step_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && fine_en) |=> (phase_w == $past(phase_w) + $past(ftw)));

  // R4
  phase_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && fine_en) |=> $stable(phase_w));

  // R5
  sine_range_chk: assert property (@(posedge clk) disable iff (rst)
    sin_w != MOSTNEG);
endmodule

bind nco_fine_shifter nco_shift_chk #(.DW(DW), .PW(PW), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
  .ftw(ftw), .fine_en(fine_en), .out_valid(out_valid), .out_i(out_i),
  .out_q(out_q), .phase_w(phase_w), .sin_w(sin_w)
);

// File: tb/nco_fine_shifter_bench.sv
module nco_fine_shifter_bench;
  localparam int CLK_PERIOD = 10;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               in_valid = 1'b0;
  logic signed [15:0] in_i = '0;
  logic signed [15:0] in_q = '0;
  logic [23:0]        ftw = '0;
  logic               fine_en = 1'b0;
  logic               neg_shift = 1'b0;
  logic               out_valid;
  logic signed [15:0] out_i;
  logic signed [15:0] out_q;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  nco_fine_shifter u_nco_fine_shifter (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .ftw(ftw), .fine_en(fine_en), .neg_shift(neg_shift),
    .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
  );

  // bench model state
  logic [23:0]        b_ph;
  bit                 e_v [0:2];
  logic signed [15:0] e_i [0:2];
  logic signed [15:0] e_q [0:2];
  string              e_t [0:2];

  // R5: half-period parabola, sign from the top index bit
  function automatic longint b_sin(input int p);
    int m;
    longint v;
    m = p % 128;
    v = (longint'(32767) * m * (128 - m)) / 4096;
    return (p >= 128) ? -v : v;
  endfunction

  // R8 R9
  function automatic longint b_rs(input longint s, output bit clamped);
    longint r;
    r = (s + 16384) >>> 15;
    clamped = 1'b0;
    if (r > 32767)  begin r = 32767;  clamped = 1'b1; end
    if (r < -32768) begin r = -32768; clamped = 1'b1; end
    return r;
  endfunction

  task automatic model_clear();
    b_ph = '0;
    for (int k = 0; k < 3; k++) begin
      e_v[k] = 1'b0; e_i[k] = '0; e_q[k] = '0; e_t[k] = "";
    end
  endtask

  task automatic cycle(input bit v, input int si, input int sq, input logic [23:0] w,
                       input bit fe, input bit ng);
    longint c, s, xi, xq;
    bit c1, c2;
    int p;
    @(negedge clk);
    checks++;
    if (out_valid !== e_v[2]) begin
      errors++;
      $display("FAIL R2 out_valid actual %0b expected %0b", out_valid, e_v[2]);
    end else if (e_v[2]) begin
      checks++;
      if (out_i !== e_i[2] || out_q !== e_q[2]) begin
        errors++;
        $display("FAIL %s actual (%0d,%0d) expected (%0d,%0d)",
                 e_t[2], out_i, out_q, e_i[2], e_q[2]);
      end
    end
    in_valid = v; in_i = 16'(si); in_q = 16'(sq); ftw = w; fine_en = fe; neg_shift = ng;
    e_v[2] = e_v[1]; e_i[2] = e_i[1]; e_q[2] = e_q[1]; e_t[2] = e_t[1];
    e_v[1] = e_v[0]; e_i[1] = e_i[0]; e_q[1] = e_q[0]; e_t[1] = e_t[0];
    e_v[0] = v;
    if (!fe) begin
      e_i[0] = 16'(si); e_q[0] = 16'(sq); e_t[0] = "R3 bypass";
    end else begin
      p = int'(b_ph[23:16]);
      s = b_sin(p);
      c = b_sin((p + 64) % 256);
      if (!ng) begin
        xi = si * c - sq * s; xq = si * s + sq * c;
        e_t[0] = "R6 up-shift R4 R5 R8";
      end else begin
        xi = si * c + sq * s; xq = sq * c - si * s;
        e_t[0] = "R7 down-shift R4 R5 R8";
      end
      e_i[0] = 16'(b_rs(xi, c1));
      e_q[0] = 16'(b_rs(xq, c2));
      if (c1 || c2) e_t[0] = {e_t[0], " R9 clamp"};
    end
    if (v && fe) b_ph = b_ph + w;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_i !== '0 || out_q !== '0) begin
      errors++;
      $display("FAIL R1 reset outputs actual (%0b,%0d,%0d) expected (0,0,0)",
               out_valid, out_i, out_q);
    end
    model_clear();
    rst = 1'b0;
  endtask

  initial begin
    int seed;
    logic [23:0] w;
    seed = $urandom(32'h5EED_0A11);
    model_clear();
    do_reset();

    // R3: bypass of random samples, accumulator must stay put (R4)
    for (int n = 0; n < 20; n++) cycle(1, $urandom_range(65535) - 32768, $urandom_range(65535) - 32768, 24'h123456, 0, n[0]);

    // R4 R5: zero word keeps phase 0, full-scale input at cos=32767
    for (int n = 0; n < 4; n++) cycle(1, 32767, -32768, 24'h0, 1, 0);

    // R9: eighth-turn steps reach 45 degrees with full-scale input, both directions
    for (int n = 0; n < 10; n++) cycle(1, 32767, -32768, 24'h200000, 1, 0);
    for (int n = 0; n < 10; n++) cycle(1, -32768, 32767, 24'h200000, 1, 1);

    // R4: wrap of the accumulator with the largest word
    for (int n = 0; n < 8; n++) cycle(1, 20000, -12345, 24'hFFFFFF, 1, n[1]);

    // R1: reset mid-stream restarts the phase at zero
    for (int n = 0; n < 2; n++) cycle(1, 1000, 2000, 24'h0A0000, 1, 0);
    do_reset();
    for (int n = 0; n < 6; n++) cycle(1, 30000, 5000, 24'h0A0000, 1, 0);

    // random mix of gaps, modes and words
    w = 24'(($urandom_range(65535) << 8) | $urandom_range(255));
    for (int n = 0; n < 3000; n++) begin
      if ($urandom_range(63) == 0) w = 24'(($urandom_range(65535) << 8) | $urandom_range(255));
      cycle($urandom_range(3) != 0,
            $urandom_range(65535) - 32768, $urandom_range(65535) - 32768,
            w, $urandom_range(7) != 0, $urandom_range(1) == 1);
    end
    for (int n = 0; n < 4; n++) cycle(0, 0, 0, w, 1, 0);

    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule